// File: doc/BRIEF.md
# S/PDIF Receiver Control and Interrupt Unit

This unit holds the operating mode of an S/PDIF receiver and gathers the status events that the line decoder reports. Software moves the receiver through three modes with a 2-bit mode field: idle, locking onto the incoming stream, and full sample reception. The unit tells the decoder when to run, keeps a nine-bit status word, filters it through an interrupt-enable mask and drives one registered interrupt line.

Three kinds of status flag exist. Two ready flags follow the data and control-word buffers and drop when those buffers are read. Four sticky flags (parity error, overrun, sync block seen, sync done) stay set until software writes ones to their positions in the clear port. Three fatal flags (frame error, sync error, timeout) stop the receiver. Only a write of the idle mode releases them. An optional wait-for-activity setting keeps the decoder parked until the line shows transitions, so an unplugged input produces no sync errors.

Top module: `spdif_rx_ctl`

## Requirements
- R1: After reset the mode field reads 00, the decoder-run and reception outputs are low, the unit is not stopped, all status bits and interrupt enables are 0 and the interrupt is low.
- R2: The mode field is encoded 00 idle, 01 locking and 11 receiving. A write of 01 from idle with the wait setting clear makes the mode 01 and raises decEnable with rxActive low.
- R3: A write of 11 takes effect only while locking or receiving and after a sync-done event has been accepted since the last idle write. Otherwise it acts as a write of 01. In mode 11, rxActive and decEnable are high.
- R4: A write of the reserved code 10 leaves the mode and the decoder outputs unchanged.
- R5: With the wait setting high on the write that leaves idle, the mode reads 01 but decEnable stays low until a lineActivity pulse arrives. decEnable then rises on the following cycle.
- R6: Status events are taken only while the decoder runs (locking or receiving). In idle, while waiting for activity, in the stopped state and in the cycle of an idle write they leave the status unchanged.
- R7: Status bit positions are 0 data ready, 1 control ready, 2 parity, 3 overrun, 4 sync block, 5 sync done, 6 frame error, 7 sync error and 8 timeout. Bits 2 to 5 are sticky and a one at the same position in a clear write clears them. Clear-port bits 0, 1 and 6 to 8 have no effect.
- R8: Ready bit 0 clears on a dataRead pulse and bit 1 on a capRead pulse. The clear port does not touch them.
- R9: An accepted event on bit 6, 7 or 8 stops the receiver. While stopped, decEnable and rxActive are low and mode writes other than 00 are ignored.
- R10: A write of mode 00 clears status bits 6 to 8, leaves the stopped state and forgets sync done.
- R11: Interrupt-enable bits 0 to 6 gate status bits 0 to 6. Enable bit 6 also gates status bits 7 and 8.
- R12: irq is high one cycle after any status bit and its effective enable are both high.
- R13: An event that arrives in the same cycle as a clear of its flag leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode write strobe |
| modeWrVal | input | 2 | Mode value written |
| modeWrWait | input | 1 | Wait-for-activity setting sampled with a mode write |
| lineActivity | input | 1 | Pulse: transitions seen on the input line |
| ieWrEn | input | 1 | Interrupt-enable write strobe |
| ieWrVal | input | 7 | Interrupt-enable value |
| clrWrEn | input | 1 | Clear-port write strobe |
| clrWrMask | input | 9 | Write-one-to-clear mask |
| dataRead | input | 1 | Data buffer read pulse |
| capRead | input | 1 | Control-word buffer read pulse |
| evIn | input | 9 | Event pulses from the decoder, bit layout as status |
| modeField | output | 2 | Current mode field |
| decEnable | output | 1 | Decoder run enable |
| rxActive | output | 1 | Full reception active |
| stopped | output | 1 | Receiver halted by a fatal error |
| status | output | 9 | Status word |
| irqEnable | output | 7 | Interrupt-enable register |
| irq | output | 1 | Registered interrupt |

## Verification
The assertions assume that evIn, the clear mask and the read pulses are single-cycle strobes sampled at the rising edge, and that no event comes from a decoder that has not been started. They also assume that a mode write and a fatal event in the same cycle resolve in favour of the idle write. The stimulus drives every input at the falling edge and returns it to zero after one cycle. It keeps fatal events rare and idle writes frequent enough that the random run keeps leaving the stopped state and returning to lock and receive.

// File: rtl/spdif_rx_ctl_pkg.sv
package spdif_rx_ctl_pkg;
  localparam int MODE_W = 2;
  localparam int STAT_W = 9;
  localparam int IE_W   = 7;

  localparam logic [MODE_W-1:0] MODE_OFF  = 2'b00;
  localparam logic [MODE_W-1:0] MODE_SYNC = 2'b01;
  localparam logic [MODE_W-1:0] MODE_RSVD = 2'b10;
  localparam logic [MODE_W-1:0] MODE_RUN  = 2'b11;

  // status bit positions, decoded by the neighbouring decoder and software
  localparam int BIT_DRDY  = 0;
  localparam int BIT_CRDY  = 1;
  localparam int BIT_PAR   = 2;
  localparam int BIT_OVR   = 3;
  localparam int BIT_SBLK  = 4;
  localparam int BIT_SDONE = 5;
  localparam int BIT_FERR  = 6;
  localparam int BIT_SERR  = 7;
  localparam int BIT_TERR  = 8;

  localparam int STICKY_LO = BIT_PAR;
  localparam int STICKY_HI = BIT_SDONE;
  localparam int FATAL_LO  = BIT_FERR;
  localparam int FATAL_HI  = BIT_TERR;

  typedef enum logic [2:0] {
    ST_OFF, ST_WAIT, ST_SYNC, ST_RUN, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic acceptEv;
    logic clearFatal;
  } ctlStrobe_t;
endpackage

// File: rtl/spdif_rx_mode_fsm.sv
module spdif_rx_mode_fsm
  import spdif_rx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrVal,
  input  logic              modeWrWait,
  input  logic              lineActivity,
  input  logic              evFatal,
  input  logic              evSyncDone,
  output ctlStrobe_t        strobe,
  output logic [MODE_W-1:0] modeField,
  output logic              decEnable,
  output logic              rxActive,
  output logic              stopped
);
  rxState_t          state, stateNext;
  logic [MODE_W-1:0] modeReg, modeNext;
  logic              syncOk, syncOkNext;
  logic              offWrite, running, takeFull;

  always_comb begin
    offWrite = modeWrEn && (modeWrVal == MODE_OFF);
    running  = (state == ST_SYNC) || (state == ST_RUN);
    strobe.acceptEv   = running && !offWrite;
    strobe.clearFatal = offWrite;
    takeFull = (modeWrVal == MODE_RUN) && syncOk && running;
  end

  always_comb begin
    stateNext  = state;
    modeNext   = modeReg;
    syncOkNext = syncOk;
    if (strobe.acceptEv && evSyncDone) syncOkNext = 1'b1;
    if (offWrite) begin
      stateNext  = ST_OFF;
      modeNext   = MODE_OFF;
      syncOkNext = 1'b0;
    end else if (strobe.acceptEv && evFatal) begin
      stateNext = ST_STOP;
    end else if (state == ST_STOP) begin
      stateNext = ST_STOP;
    end else if (modeWrEn && (modeWrVal != MODE_RSVD)) begin
      if (takeFull) begin
        stateNext = ST_RUN;
        modeNext  = MODE_RUN;
      end else begin
        modeNext = MODE_SYNC;
        unique case (state)
          ST_OFF:  stateNext = modeWrWait ? ST_WAIT : ST_SYNC;
          ST_WAIT: stateNext = lineActivity ? ST_SYNC : ST_WAIT;
          default: stateNext = ST_SYNC;
        endcase
      end
    end else if ((state == ST_WAIT) && lineActivity) begin
      stateNext = ST_SYNC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_OFF;
      modeReg <= MODE_OFF;
      syncOk  <= 1'b0;
    end else begin
      state   <= stateNext;
      modeReg <= modeNext;
      syncOk  <= syncOkNext;
    end
  end

  assign modeField = modeReg;
  assign decEnable = (state == ST_SYNC) || (state == ST_RUN);
  assign rxActive  = (state == ST_RUN);
  assign stopped   = (state == ST_STOP);
endmodule

// File: rtl/spdif_rx_status_dp.sv
module spdif_rx_status_dp
  import spdif_rx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [STAT_W-1:0] evIn,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrWrMask,
  input  logic              ieWrEn,
  input  logic [IE_W-1:0]   ieWrVal,
  input  logic              dataRead,
  input  logic              capRead,
  output logic [STAT_W-1:0] status,
  output logic [IE_W-1:0]   irqEnable,
  output logic              irq
);
  localparam int EXT_W = STAT_W - IE_W;

  logic [STAT_W-1:0] flagClr;
  logic [STAT_W-1:0] flagSet;
  logic [STAT_W-1:0] effEn;

  assign flagSet = strobe.acceptEv ? evIn : '0;

  for (genvar i = 0; i < STAT_W; i++) begin : g_flag
    if (i == BIT_DRDY) begin : g_drdy
      assign flagClr[i] = dataRead;
    end else if (i == BIT_CRDY) begin : g_crdy
      assign flagClr[i] = capRead;
    end else if (i >= STICKY_LO && i <= STICKY_HI) begin : g_sticky
      assign flagClr[i] = clrWrEn && clrWrMask[i];
    end else begin : g_fatal
      assign flagClr[i] = strobe.clearFatal;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          status[i] <= 1'b0;
      else if (flagSet[i]) status[i] <= 1'b1;
      else if (flagClr[i]) status[i] <= 1'b0;
    end
  end

  // frame-error enable also covers the two flags above the enable field
  assign effEn = {{EXT_W{irqEnable[BIT_FERR]}}, irqEnable};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqEnable <= '0;
      irq       <= 1'b0;
    end else begin
      if (ieWrEn) irqEnable <= ieWrVal;
      irq <= |(status & effEn);
    end
  end
endmodule

// File: rtl/spdif_rx_ctl.sv
module spdif_rx_ctl
  import spdif_rx_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              modeWrEn,
  input  logic [MODE_W-1:0] modeWrVal,
  input  logic              modeWrWait,
  input  logic              lineActivity,
  input  logic              ieWrEn,
  input  logic [IE_W-1:0]   ieWrVal,
  input  logic              clrWrEn,
  input  logic [STAT_W-1:0] clrWrMask,
  input  logic              dataRead,
  input  logic              capRead,
  input  logic [STAT_W-1:0] evIn,
  output logic [MODE_W-1:0] modeField,
  output logic              decEnable,
  output logic              rxActive,
  output logic              stopped,
  output logic [STAT_W-1:0] status,
  output logic [IE_W-1:0]   irqEnable,
  output logic              irq
);
  ctlStrobe_t strobe;

  spdif_rx_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .modeWrEn     (modeWrEn),
    .modeWrVal    (modeWrVal),
    .modeWrWait   (modeWrWait),
    .lineActivity (lineActivity),
    .evFatal      (|evIn[FATAL_HI:FATAL_LO]),
    .evSyncDone   (evIn[BIT_SDONE]),
    .strobe       (strobe),
    .modeField    (modeField),
    .decEnable    (decEnable),
    .rxActive     (rxActive),
    .stopped      (stopped)
  );

  spdif_rx_status_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .evIn      (evIn),
    .clrWrEn   (clrWrEn),
    .clrWrMask (clrWrMask),
    .ieWrEn    (ieWrEn),
    .ieWrVal   (ieWrVal),
    .dataRead  (dataRead),
    .capRead   (capRead),
    .status    (status),
    .irqEnable (irqEnable),
    .irq       (irq)
  );
endmodule

// File: rtl/spdif_rx_ctl_checker.sv
module spdif_rx_ctl_checker
  import spdif_rx_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] modeField,
  input logic              decEnable,
  input logic              rxActive,
  input logic              stopped,
  input logic [STAT_W-1:0] status,
  input logic [IE_W-1:0]   irqEnable,
  input logic              irq,
  input logic              clrWrEn,
  input logic [STAT_W-1:0] clrWrMask,
  input logic              dataRead,
  input logic [STAT_W-1:0] evIn
);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> (!decEnable && !rxActive));

  assert_fatal_holds_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|status[FATAL_HI:FATAL_LO]) |-> stopped);

  assert_no_reserved_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    modeField != MODE_RSVD);

  assert_full_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rxActive |-> (modeField == MODE_RUN));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (modeField == MODE_OFF) |-> (!decEnable && status[FATAL_HI:FATAL_LO] == '0));

  assert_irq_lag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(status & {irqEnable[BIT_FERR], irqEnable[BIT_FERR], irqEnable})));

  assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clrWrEn && clrWrMask[BIT_PAR] && !evIn[BIT_PAR]) |=> !status[BIT_PAR]);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dataRead && !evIn[BIT_DRDY]) |=> !status[BIT_DRDY]);
endmodule

bind spdif_rx_ctl spdif_rx_ctl_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .modeField (modeField),
  .decEnable (decEnable),
  .rxActive  (rxActive),
  .stopped   (stopped),
  .status    (status),
  .irqEnable (irqEnable),
  .irq       (irq),
  .clrWrEn   (clrWrEn),
  .clrWrMask (clrWrMask),
  .dataRead  (dataRead),
  .evIn      (evIn)
);

// File: tb/spdif_rx_ctl_test.sv
module spdif_rx_ctl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       modeWrEn, modeWrWait, lineActivity, ieWrEn, clrWrEn, dataRead, capRead;
  logic [1:0] modeWrVal;
  logic [6:0] ieWrVal;
  logic [8:0] clrWrMask, evIn;
  logic [1:0] modeField;
  logic       decEnable, rxActive, stopped, irq;
  logic [8:0] status;
  logic [6:0] irqEnable;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  // bench model
  int         mState;   // 0 idle, 1 wait, 2 lock, 3 receive, 4 stopped
  logic [1:0] mMode;
  logic       mSyncOk, mIrq;
  logic [8:0] mStatus;
  logic [6:0] mIe;

  always #4 clk = ~clk;

  spdif_rx_ctl uut (
    .clk(clk), .rst_n(rst_n), .modeWrEn(modeWrEn), .modeWrVal(modeWrVal),
    .modeWrWait(modeWrWait), .lineActivity(lineActivity), .ieWrEn(ieWrEn),
    .ieWrVal(ieWrVal), .clrWrEn(clrWrEn), .clrWrMask(clrWrMask),
    .dataRead(dataRead), .capRead(capRead), .evIn(evIn),
    .modeField(modeField), .decEnable(decEnable), .rxActive(rxActive),
    .stopped(stopped), .status(status), .irqEnable(irqEnable), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] effMask(input logic [6:0] ie);
    return {ie[6], ie[6], ie};
  endfunction

  task automatic modelTick();
    logic       offW, acc;
    logic [8:0] s;
    offW = modeWrEn && (modeWrVal == 2'b00);
    acc  = (mState == 2 || mState == 3) && !offW;
    mIrq = |(mStatus & effMask(mIe));
    s = mStatus;
    if (clrWrEn) s[5:2] = s[5:2] & ~clrWrMask[5:2];
    if (dataRead) s[0] = 1'b0;
    if (capRead) s[1] = 1'b0;
    if (offW) s[8:6] = 3'b000;
    if (acc) s = s | evIn;
    if (ieWrEn) mIe = ieWrVal;
    if (offW) begin
      mState = 0; mMode = 2'b00; mSyncOk = 1'b0;
    end else begin
      logic oldOk;
      oldOk = mSyncOk;
      if (acc && evIn[5]) mSyncOk = 1'b1;
      if (acc && (|evIn[8:6])) mState = 4;
      else if (mState == 4) mState = 4;
      else if (modeWrEn && modeWrVal != 2'b10) begin
        if (modeWrVal == 2'b11 && oldOk && (mState == 2 || mState == 3)) begin
          mState = 3; mMode = 2'b11;
        end else begin
          mMode = 2'b01;
          if (mState == 0) mState = modeWrWait ? 1 : 2;
          else if (mState == 1) mState = lineActivity ? 2 : 1;
          else mState = 2;
        end
      end else if (mState == 1 && lineActivity) mState = 2;
    end
    mStatus = s;
  endtask

  task automatic modelCompare();
    chk("R2 mode field", modeField, mMode);
    chk("R9 run/stop outputs", {stopped, rxActive, decEnable},
        {mState == 4, mState == 3, (mState == 2 || mState == 3)});
    chk("R7 status word", status, mStatus);
    chk("R11 enable register", irqEnable, mIe);
    chk("R12 interrupt", irq, mIrq);
  endtask

  task automatic clearInputs();
    modeWrEn = 0; modeWrVal = 0; modeWrWait = 0; lineActivity = 0;
    ieWrEn = 0; ieWrVal = 0; clrWrEn = 0; clrWrMask = 0;
    dataRead = 0; capRead = 0; evIn = 0;
  endtask

  task automatic step();
    @(posedge clk);
    modelTick();
    @(negedge clk);
    modelCompare();
    clearInputs();
  endtask

  task automatic wrMode(input logic [1:0] v, input logic w);
    modeWrEn = 1; modeWrVal = v; modeWrWait = w; step();
  endtask
  task automatic wrIe(input logic [6:0] v);
    ieWrEn = 1; ieWrVal = v; step();
  endtask
  task automatic wrClr(input logic [8:0] m);
    clrWrEn = 1; clrWrMask = m; step();
  endtask
  task automatic ev(input logic [8:0] e);
    evIn = e; step();
  endtask

  initial begin
    clearInputs();
    rst_n = 0;
    mState = 0; mMode = 0; mSyncOk = 0; mIrq = 0; mStatus = 0; mIe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset mode", modeField, 0);
    chk("R1 reset outputs", {stopped, rxActive, decEnable, irq}, 0);
    chk("R1 reset status", status, 0);
    chk("R1 reset enables", irqEnable, 0);

    // R6: events in idle are dropped
    ev(9'h1FF);
    chk("R6 idle events ignored", status, 0);

    wrIe(7'h7F);
    wrMode(2'b01, 1'b0);
    chk("R2 lock mode", {modeField, decEnable, rxActive}, {2'b01, 1'b1, 1'b0});
    wrMode(2'b11, 1'b0);
    chk("R3 full mode refused before sync done", {modeField, rxActive}, {2'b01, 1'b0});
    wrMode(2'b10, 1'b0);
    chk("R4 reserved code ignored", {modeField, decEnable}, {2'b01, 1'b1});
    ev(9'h020);
    chk("R7 sync done flag", status, 9'h020);
    step();
    chk("R12 irq one cycle later", irq, 1);
    wrMode(2'b11, 1'b0);
    chk("R3 full mode accepted", {modeField, rxActive, decEnable}, {2'b11, 1'b1, 1'b1});

    // R13: set beats clear
    evIn = 9'h008; clrWrEn = 1; clrWrMask = 9'h008; step();
    chk("R13 set wins over clear", status[3], 1);
    ev(9'h014);
    wrClr(9'h1C3);
    chk("R7 non-sticky clear bits no effect", status, 9'h03C);
    wrClr(9'h03C);
    chk("R7 sticky bits cleared", status, 0);
    ev(9'h003);
    wrClr(9'h1FF);
    chk("R8 ready bits survive clear port", status[1:0], 2'b11);
    dataRead = 1; step();
    chk("R8 data read clears bit 0", status[1:0], 2'b10);
    capRead = 1; step();
    chk("R8 control read clears bit 1", status[1:0], 2'b00);

    // R11 / R9: timeout behind the frame-error enable
    wrIe(7'h40);
    ev(9'h100);
    chk("R9 stopped after timeout", {stopped, decEnable, rxActive}, {1'b1, 1'b0, 1'b0});
    step();
    chk("R11 frame enable covers timeout", irq, 1);
    wrMode(2'b01, 1'b0);
    chk("R9 writes ignored while stopped", {stopped, modeField}, {1'b1, 2'b11});
    ev(9'h004);
    chk("R6 events ignored while stopped", status[2], 0);
    wrIe(7'h3F);
    step();
    chk("R11 other enables do not cover bit 8", irq, 0);
    wrMode(2'b00, 1'b0);
    chk("R10 idle write releases stop", {stopped, status[8:6], modeField}, 0);

    // R5: wait for activity
    wrMode(2'b01, 1'b1);
    chk("R5 waiting, decoder parked", {modeField, decEnable}, {2'b01, 1'b0});
    ev(9'h080);
    chk("R5 sync error ignored while waiting", status[8:6], 0);
    lineActivity = 1; step();
    chk("R5 activity starts decoder", decEnable, 1);
    wrMode(2'b11, 1'b0);
    chk("R10 sync done forgotten after idle", modeField, 2'b01);
    wrMode(2'b00, 1'b0);

    // constrained random
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 8 == 0) begin
        modeWrEn = 1;
        modeWrVal = (($urandom % 12) == 0) ? 2'b00 : 2'($urandom);
        modeWrWait = ($urandom % 3 == 0);
      end
      lineActivity = ($urandom % 10 == 0);
      if ($urandom % 20 == 0) begin ieWrEn = 1; ieWrVal = 7'($urandom); end
      if ($urandom % 8 == 0) begin clrWrEn = 1; clrWrMask = 9'($urandom); end
      dataRead = ($urandom % 5 == 0);
      capRead = ($urandom % 5 == 0);
      for (int b = 0; b < 6; b++) evIn[b] = ($urandom % 6 == 0);
      for (int b = 6; b < 9; b++) evIn[b] = ($urandom % 96 == 0);
      step();
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule